// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex serial port that moves one byte at a time over a single data line. While it moves the byte it drives its own shift clock on a second line. It either sends a byte written into it, least significant bit first, or captures a byte from the line. All timing comes from a machine cycle of twelve phase ticks. A free-running phase counter advances one position on each clock where the one-cycle `tick_en` strobe is high.

Phase positions are numbered 0 to 11. State s, half q (s = 1..6, q = 1..2) maps to index 2(s-1)+(q-1). Index 0 is the first half of state 1, index 4 is the first half of state 3, index 9 is the second half of state 5, index 10 is the first half of state 6, and index 11 is the second half of state 6.

No bit counter is used. A send ends when a marker '1', placed above the byte, has moved down to sit next to the output bit. A receive ends when a lone '0', preloaded at the low end of a register of ones, has climbed to the top.

Top module: `ssp_port`

## Requirements
- R1: After reset, `sclk`=1, `data_oe`=0, `data_out`=1, `tx_done`=0, `rx_done`=0 and `rx_byte`=0.
- R2: A `wr_buf` strobe while idle captures `wr_data`. The machine cycle in which the strobe arrives is cycle 0. During cycles 2 to 9, `data_oe`=1, and at phase index 9 of cycle k the line carries bit k-2 of the byte.
- R3: For a send, `tx_done` rises and `data_oe` falls on the phase-0 tick of cycle 10. Just before that tick, `data_out` shows the marker value 1.
- R4: `sclk` is 1 whenever no transfer is running. While a transfer runs, it falls on the phase-4 tick and rises on the phase-10 tick of every cycle.
- R5: A receive is started only from idle, and only when `rx_enable`=1 and `rx_done`=0. With `rx_done`=1, no receive starts and `sclk` stays high.
- R6: During a receive, `data_oe`=0. `data_in` is captured on the phase-9 tick of cycles 2 to 9. The bit captured in cycle k becomes bit k-2 of `rx_byte`.
- R7: For a receive, `rx_done` rises on the phase-0 tick of cycle 10 after the start condition is seen. `rx_byte` holds the new byte by then.
- R8: `tx_done` and `rx_done` stay set until their own clear strobe (`tx_clr`, `rx_clr`) arrives.
- R9: A `wr_buf` strobe during a receive has no effect: the received byte is intact, `data_oe` stays 0 and `tx_done` stays 0.
- R10: A receive start condition that holds only while a send is running has no effect: no receive follows the send.
- R11: Without `tick_en`, `sclk`, `data_out` and `data_oe` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Phase advance enable, one clock wide |
| wr_buf | input | 1 | Byte write strobe, starts a send |
| wr_data | input | 8 | Byte to send |
| tx_clr | input | 1 | Clears the transmit-done flag |
| rx_enable | input | 1 | Allows a receive to start |
| rx_clr | input | 1 | Clears the receive-done flag |
| data_in | input | 1 | Serial data line input |
| data_out | output | 1 | Serial data line output value |
| data_oe | output | 1 | Drive enable for the serial data line |
| sclk | output | 1 | Shift clock |
| rx_byte | output | 8 | Last received byte |
| tx_done | output | 1 | Transmit-done flag |
| rx_done | output | 1 | Receive-done flag |

## Verification
The assertions check rules that must hold on every cycle:
- the shift clock is high when idle and falls only on a phase-4 tick;
- nothing visible on the line moves without a tick;
- the line is never driven during a receive;
- the done flags rise only on a phase-0 tick;
- the receive-done flag holds until it is cleared.

Only the bench scenarios can show the exact tenth-cycle completion, the bit order on the line, the capture at the phase-9 tick, and the rejection of strobes and start conditions. They do so by sweeping every byte value in both directions.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int PH_COUNT = 12;
    localparam int PH_W     = $clog2(PH_COUNT);

    typedef logic [PH_W-1:0] ph_t;

    // phase index = 2*(state-1) + (half-1)
    localparam ph_t PH_S1P1      = ph_t'(0);
    localparam ph_t PH_SCLK_FALL = ph_t'(4);
    localparam ph_t PH_SAMPLE    = ph_t'(9);
    localparam ph_t PH_SCLK_RISE = ph_t'(10);
    localparam ph_t PH_PRELOAD   = ph_t'(11);

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_ARM  = 2'd1,
        SQ_WAIT = 2'd2,
        SQ_RUN  = 2'd3
    } sq_state_e;

    typedef enum logic {
        XF_TX = 1'b0,
        XF_RX = 1'b1
    } xfer_dir_e;

    // per-tick event strobes, one per pinned phase
    typedef struct packed {
        logic first;
        logic fall;
        logic sample;
        logic rise;
        logic preload;
    } ph_evt_t;

    function automatic ph_t next_ph(input ph_t ph);
        return (ph == ph_t'(PH_COUNT - 1)) ? ph_t'(0) : ph + ph_t'(1);
    endfunction

    function automatic ph_evt_t decode_evt(input logic tick, input ph_t ph);
        ph_evt_t e;
        e.first   = tick && (ph == PH_S1P1);
        e.fall    = tick && (ph == PH_SCLK_FALL);
        e.sample  = tick && (ph == PH_SAMPLE);
        e.rise    = tick && (ph == PH_SCLK_RISE);
        e.preload = tick && (ph == PH_PRELOAD);
        return e;
    endfunction

endpackage

// File: rtl/ssp_phase_gen.sv
module ssp_phase_gen
    import ssp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick_en,
    output ph_t     ph,
    output ph_evt_t evt
);

    ph_t ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_S1P1;
        end else if (tick_en) begin
            ph_q <= next_ph(ph_q);
        end
    end

    // events belong to the phase being executed by this tick
    assign ph  = ph_q;
    assign evt = decode_evt(tick_en, ph_q);

endmodule

// File: rtl/ssp_seq.sv
module ssp_seq
    import ssp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ph_evt_t   evt,
    input  logic      wr_buf,
    input  logic      rx_enable,
    input  logic      tx_clr,
    input  logic      rx_clr,
    input  logic      end_seen,
    output xfer_dir_e dir,
    output logic      run,
    output logic      tx_accept,
    output logic      rx_init,
    output logic      shift_en,
    output logic      capture_en,
    output logic      fall_en,
    output logic      tx_done,
    output logic      rx_done
);

    sq_state_e state;
    logic      fin_q;
    logic      rx_arm;
    logic      finish;

    always_comb begin
        tx_accept  = (state == SQ_IDLE) && wr_buf;
        rx_arm     = (state == SQ_IDLE) && !wr_buf && rx_enable && !rx_done;
        run        = (state == SQ_RUN);
        rx_init    = (state == SQ_WAIT) && evt.preload && (dir == XF_RX);
        shift_en   = run && evt.rise;
        capture_en = run && evt.sample && (dir == XF_RX);
        fall_en    = run && evt.fall;
        finish     = run && evt.first && fin_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            dir     <= XF_TX;
            fin_q   <= 1'b0;
            tx_done <= 1'b0;
            rx_done <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (tx_accept) begin
                        state <= SQ_ARM;
                        dir   <= XF_TX;
                    end else if (rx_arm) begin
                        state <= SQ_ARM;
                        dir   <= XF_RX;
                    end
                end
                SQ_ARM:  if (evt.first)   state <= SQ_WAIT;
                SQ_WAIT: if (evt.preload) state <= SQ_RUN;
                SQ_RUN:  if (finish)      state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase

            // a marker seen before a shift arms the final shift
            if (finish) begin
                fin_q <= 1'b0;
            end else if (shift_en && end_seen) begin
                fin_q <= 1'b1;
            end

            if (finish && dir == XF_TX) begin
                tx_done <= 1'b1;
            end else if (tx_clr) begin
                tx_done <= 1'b0;
            end

            if (finish && dir == XF_RX) begin
                rx_done <= 1'b1;
            end else if (rx_clr) begin
                rx_done <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  xfer_dir_e         dir,
    input  logic              run,
    input  logic              tx_accept,
    input  logic              rx_init,
    input  logic              shift_en,
    input  logic              capture_en,
    input  logic              fall_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              data_in,
    output logic              end_seen,
    output logic              data_out,
    output logic              data_oe,
    output logic              sclk,
    output logic [DATA_W-1:0] rx_byte
);

    localparam int TX_W = DATA_W + 1;
    localparam logic [DATA_W-1:0] TX_MARK_AT_END = DATA_W'(1);
    localparam logic [DATA_W-1:0] RX_PRELOAD = {{(DATA_W-1){1'b1}}, 1'b0};

    logic [TX_W-1:0]   tx_sr;
    logic [DATA_W-1:0] rx_sr;
    logic [DATA_W-1:0] rx_next;
    logic [DATA_W-1:0] rx_rev;
    logic [DATA_W-1:0] rx_buf;
    logic              samp;
    logic              sclk_q;
    logic              tx_end;
    logic              rx_end;

    assign rx_next = {rx_sr[DATA_W-2:0], samp};

    // first bit on the line ends up at the top after the last shift
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign rx_rev[i] = rx_next[DATA_W-1-i];
    end

    assign tx_end   = (tx_sr[TX_W-1:1] == TX_MARK_AT_END);
    assign rx_end   = !rx_sr[DATA_W-1];
    assign end_seen = (dir == XF_TX) ? tx_end : rx_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr  <= '0;
            rx_sr  <= '1;
            rx_buf <= '0;
            samp   <= 1'b1;
            sclk_q <= 1'b1;
        end else begin
            if (tx_accept) begin
                tx_sr <= {1'b1, wr_data};
            end else if (shift_en && dir == XF_TX) begin
                tx_sr <= {1'b0, tx_sr[TX_W-1:1]};
            end

            if (rx_init) begin
                rx_sr <= RX_PRELOAD;
            end else if (shift_en && dir == XF_RX) begin
                rx_sr <= rx_next;
            end

            if (capture_en) begin
                samp <= data_in;
            end

            if (shift_en && dir == XF_RX && rx_end) begin
                rx_buf <= rx_rev;
            end

            if (fall_en) begin
                sclk_q <= 1'b0;
            end else if (shift_en) begin
                sclk_q <= 1'b1;
            end
        end
    end

    assign data_oe  = run && (dir == XF_TX);
    assign data_out = data_oe ? tx_sr[0] : 1'b1;
    assign sclk     = sclk_q;
    assign rx_byte  = rx_buf;

endmodule

// File: rtl/ssp_port.sv
module ssp_port
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_buf,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tx_clr,
    input  logic              rx_enable,
    input  logic              rx_clr,
    input  logic              data_in,
    output logic              data_out,
    output logic              data_oe,
    output logic              sclk,
    output logic [DATA_W-1:0] rx_byte,
    output logic              tx_done,
    output logic              rx_done
);

    ph_t       ph;
    ph_evt_t   evt;
    xfer_dir_e seq_dir;
    logic      seq_run;
    logic      tx_accept;
    logic      rx_init;
    logic      shift_en;
    logic      capture_en;
    logic      fall_en;
    logic      end_seen;

    ssp_phase_gen u_phase (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .ph      (ph),
        .evt     (evt)
    );

    ssp_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .wr_buf     (wr_buf),
        .rx_enable  (rx_enable),
        .tx_clr     (tx_clr),
        .rx_clr     (rx_clr),
        .end_seen   (end_seen),
        .dir        (seq_dir),
        .run        (seq_run),
        .tx_accept  (tx_accept),
        .rx_init    (rx_init),
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .fall_en    (fall_en),
        .tx_done    (tx_done),
        .rx_done    (rx_done)
    );

    ssp_shifter #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk        (clk),
        .rst        (rst),
        .dir        (seq_dir),
        .run        (seq_run),
        .tx_accept  (tx_accept),
        .rx_init    (rx_init),
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .fall_en    (fall_en),
        .wr_data    (wr_data),
        .data_in    (data_in),
        .end_seen   (end_seen),
        .data_out   (data_out),
        .data_oe    (data_oe),
        .sclk       (sclk),
        .rx_byte    (rx_byte)
    );

endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk
    import ssp_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      tick_en,
    input ph_t       ph,
    input logic      run,
    input xfer_dir_e dir,
    input logic      sclk,
    input logic      data_oe,
    input logic      data_out,
    input logic      tx_done,
    input logic      rx_done,
    input logic      rx_clr
);

    // R4: idle shift clock is high
    p_sclk_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !run |-> sclk);

    // R4: shift clock falls only on the phase-4 tick
    p_sclk_fall_phase_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> ($past(tick_en) && $past(ph) == PH_SCLK_FALL));

    // R11: no tick, no visible movement
    p_no_tick_stable_r11: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> ($stable(sclk) && $stable(data_oe) && $stable(data_out)));

    // R6: line is never driven during a receive
    p_rx_no_drive_r6: assert property (@(posedge clk) disable iff (rst)
        (run && dir == XF_RX) |-> !data_oe);

    // R3: transmit-done rises only on the phase-0 tick
    p_txdone_phase_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_done) |-> ($past(tick_en) && $past(ph) == PH_S1P1));

    // R7: receive-done rises only on the phase-0 tick
    p_rxdone_phase_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_done) |-> ($past(tick_en) && $past(ph) == PH_S1P1));

    // R8: receive-done holds until cleared
    p_rxdone_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !rx_clr) |=> rx_done);

endmodule

bind ssp_port ssp_port_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .ph       (ph),
    .run      (seq_run),
    .dir      (seq_dir),
    .sclk     (sclk),
    .data_oe  (data_oe),
    .data_out (data_out),
    .tx_done  (tx_done),
    .rx_done  (rx_done),
    .rx_clr   (rx_clr)
);

// File: tb/ssp_port_test.sv
module ssp_port_test;

    localparam int CLK_PERIOD = 10;
    localparam int END_TICK   = 118; // phase-0 tick of cycle 10, starting at phase 3
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       wr_buf = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx_clr = 1'b0;
    logic       rx_enable = 1'b0;
    logic       rx_clr = 1'b0;
    logic       data_in = 1'b1;
    logic       data_out;
    logic       data_oe;
    logic       sclk;
    logic [7:0] rx_byte;
    logic       tx_done;
    logic       rx_done;

    int total = 0;
    int bad   = 0;
    int bph   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ssp_port uut (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .wr_buf    (wr_buf),
        .wr_data   (wr_data),
        .tx_clr    (tx_clr),
        .rx_enable (rx_enable),
        .rx_clr    (rx_clr),
        .data_in   (data_in),
        .data_out  (data_out),
        .data_oe   (data_oe),
        .sclk      (sclk),
        .rx_byte   (rx_byte),
        .tx_done   (tx_done),
        .rx_done   (rx_done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        bph = (bph + 1) % 12;
    endtask

    task automatic align3();
        while (bph != 3) tick();
    endtask

    task automatic pulse_wr(input logic [7:0] v);
        @(negedge clk);
        wr_buf  = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_buf  = 1'b0;
    endtask

    task automatic pulse_txclr();
        @(negedge clk);
        tx_clr = 1'b1;
        @(negedge clk);
        tx_clr = 1'b0;
    endtask

    task automatic pulse_rxclr();
        @(negedge clk);
        rx_clr = 1'b1;
        @(negedge clk);
        rx_clr = 1'b0;
    endtask

    task automatic run_tx(input logic [7:0] b);
        align3();
        pulse_wr(b);
        if (b == 8'h00) begin
            repeat (30) @(negedge clk);
            check("R11 oe without ticks", data_oe, 0);
            check("R11 sclk without ticks", sclk, 1);
        end
        for (int t = 1; t <= END_TICK; t++) begin
            int c = (t + 2) / 12;
            int p = (t + 2) % 12;
            if (b % 64 == 7) begin
                if (c == 4 && p == 0) rx_enable = 1'b1;
                if (c == 9 && p == 0) rx_enable = 1'b0;
            end
            if (c >= 2 && c <= 9 && p == 4) check("R4 sclk high before fall", sclk, 1);
            if (c >= 2 && c <= 9 && p == 9) begin
                check("R2 tx bit", data_out, b[c-2]);
                check("R2 oe during send", data_oe, 1);
                check("R4 sclk low mid cycle", sclk, 0);
            end
            if (t == END_TICK) begin
                check("R3 tx_done early", tx_done, 0);
                check("R3 marker on line", data_out, 1);
                check("R3 oe before end", data_oe, 1);
            end
            tick();
        end
        check("R3 tx_done set", tx_done, 1);
        check("R3 oe released", data_oe, 0);
        check("R4 sclk idle", sclk, 1);
        if (b % 64 == 7) begin
            repeat (12) begin
                tick();
                check("R10 no receive after send", sclk, 1);
                check("R10 line idle", data_oe, 0);
            end
        end
        repeat (3) @(negedge clk);
        check("R8 tx_done held", tx_done, 1);
        pulse_txclr();
        check("R8 tx_done cleared", tx_done, 0);
    endtask

    task automatic run_rx(input logic [7:0] b);
        align3();
        @(negedge clk);
        rx_enable = 1'b1;
        for (int t = 1; t <= END_TICK; t++) begin
            int c = (t + 2) / 12;
            int p = (t + 2) % 12;
            if (c >= 2 && c <= 9 && p == 9) begin
                data_in = b[c-2];
                check("R6 oe during receive", data_oe, 0);
                check("R4 sclk low in receive", sclk, 0);
            end
            if (c >= 2 && c <= 9 && p == 10) data_in = ~b[c-2];
            if (b % 16 == 5 && c == 5 && p == 2) pulse_wr(~b);
            if (t == END_TICK) check("R7 rx_done early", rx_done, 0);
            tick();
        end
        data_in = 1'b1;
        check("R7 rx_done set", rx_done, 1);
        check("R6 rx_byte", rx_byte, b);
        check("R4 sclk idle after receive", sclk, 1);
        if (b % 16 == 5) begin
            check("R9 write ignored tx_done", tx_done, 0);
            check("R9 write ignored oe", data_oe, 0);
        end
        if (b < 4) begin
            repeat (12) begin
                tick();
                check("R5 no start while rx_done", sclk, 1);
            end
        end
        rx_enable = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 rx_done held", rx_done, 1);
        pulse_rxclr();
        check("R8 rx_done cleared", rx_done, 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R3 actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 sclk", sclk, 1);
        check("R1 data_oe", data_oe, 0);
        check("R1 data_out", data_out, 1);
        check("R1 tx_done", tx_done, 0);
        check("R1 rx_done", rx_done, 0);
        check("R1 rx_byte", rx_byte, 0);

        // idle with receive disabled: no shift clock activity (R5)
        repeat (12) begin
            tick();
            check("R5 idle without enable", sclk, 1);
        end

        for (int v = 0; v < 256; v++) run_tx(8'(v));
        for (int v = 0; v < 256; v++) run_rx(8'(v));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule